// File: doc/BRIEF.md
# Three-Floor Elevator Car Controller

This block is a synchronous controller for an elevator car serving three floors: ground (0), first (1) and second (2). Two button sets feed it. The destination buttons are inside the car, and the call buttons are in the hallways. Each request is held on an indicator lamp until the car reaches that floor. The car moves one floor at a time. Each hop takes a fixed three seconds, and the block times this with a cycle counter derived from the clock frequency parameter.

Requests wait in a pending mask. When the door is open and no request is waiting, the car stays idle.

- **Leaving a floor:** once a request arrives and the minimum dwell has elapsed, the door closes and the car departs.
- **Stopping on the way:** the car stops at every floor it reaches that has a pending request. It opens the door there and clears both lamps of that floor.
- **Choosing a direction:** the car keeps its last travel direction while requests remain ahead of it. Otherwise it goes to the nearest pending floor, and a tie goes to the lower floor.

Button inputs are assumed to be already synchronised and debounced single-cycle pulses.

Top module: `lift3_ctrl`

## Requirements
- R1: `floor_o` reports the car position as 0 for ground, 1 for first and 2 for second. Bit i of each lamp vector and of each button vector belongs to floor i.
- R2: After reset the car is at floor 0 with the door open, both motion flags low and every lamp dark.
- R3: A destination press for floor f lights `dest_lamp_o[f]` one cycle after the press is sampled. If the car is idle with its dwell elapsed, the door closes one cycle after that.
- R4: A hall call press for floor f lights `call_lamp_o[f]` one cycle after the press is sampled. The door closes under the same timing as R3.
- R5: When the car reaches a floor with a pending request, the door opens and both lamps of that floor turn off, at the same clock edge on which `floor_o` takes the new value.
- R6: Each hop between adjacent floors lasts SECS_PER_HOP*CLK_HZ cycles, counted from the edge where the door closes or the previous floor was reached. `floor_o` changes by one floor per hop, and the matching motion flag stays high throughout the hop.
- R7: A press of either button for the floor where the car stands with its door open lights no lamp and leaves the door open.
- R8: The car stops at an intermediate floor only when that floor has a pending request. After a stop the door stays open for at least DWELL_CYC cycles, then closes if requests remain.
- R9: While requests are pending beyond the car in its last travel direction, the car keeps that direction. When none remain that way, it reverses toward the remaining requests.
- R10: An idle car with no direction history heads for the nearest pending floor, and equal distances go to the lower floor.
- R11: `moving_up_o` and `moving_dn_o` are never high together, and both are low whenever `door_open_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dest_btn | input | N_FLOORS | In-car destination request pulses, one per floor |
| call_btn | input | N_FLOORS | Hallway call request pulses, one per floor |
| floor_o | output | clog2(N_FLOORS) | Current car floor |
| door_open_o | output | 1 | Door is open |
| moving_up_o | output | 1 | Car is travelling upward |
| moving_dn_o | output | 1 | Car is travelling downward |
| dest_lamp_o | output | N_FLOORS | Pending destination indicators |
| call_lamp_o | output | N_FLOORS | Pending hall call indicators |

## Verification
Each result is due a fixed number of cycles after the edge that samples a press:

- **Lamp:** lights one cycle later.
- **Door:** closes two cycles later when the car is idle.
- **Floor change and arrival:** the floor changes a whole hop period after the door closes, and the door opens, with the lamps cleared, on the same edge as the last floor change.
- **Stop:** a stopped car departs DWELL_CYC cycles after it arrived.

The bench files every expected result under the absolute cycle number it is due, and the monitor compares it only in that cycle. For each hop the bench also checks the cycle just before the floor changes, so the hop length is pinned on both sides. An expectation that is never met counts as a miscompare.

// File: rtl/lift3_pkg.sv
package lift3_pkg;
   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_UP   = 2'd1,
      DIR_DN   = 2'd2
   } dir_e;

   typedef enum logic {
      ST_OPEN = 1'b0,
      ST_MOVE = 1'b1
   } car_st_e;
endpackage

// File: rtl/lift3_tick.sv
// Saturating cycle counter: done is high once LIMIT-1 increments have occurred.
module lift3_tick #(
   parameter int unsigned LIMIT      = 4,
   parameter bit          START_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic done
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= START_FULL ? TOP : '0;
      else if (clr)               cnt_q <= '0;
      else if (en && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign done = (cnt_q == TOP);
endmodule

// File: rtl/lift3_req_latch.sv
// One sticky request lamp per floor; clear on arrival wins over a new set.
module lift3_req_latch #(
   parameter int unsigned N_FLOORS = 3,
   parameter int unsigned FW       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_FLOORS-1:0] btn,
   input  logic                door_open,
   input  logic [FW-1:0]       floor,
   input  logic                clr_en,
   input  logic [FW-1:0]       clr_floor,
   output logic [N_FLOORS-1:0] lamp
);
   for (genvar i = 0; i < N_FLOORS; i++) begin : g_lamp
      logic blocked;
      logic lamp_q;
      assign blocked = door_open && (floor == FW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               lamp_q <= 1'b0;
         else if (clr_en && clr_floor == FW'(i))   lamp_q <= 1'b0;
         else if (btn[i] && !blocked)              lamp_q <= 1'b1;
      end
      assign lamp[i] = lamp_q;
   end
endmodule

// File: rtl/lift3_dispatch.sv
// Direction choice: keep the preferred direction while work lies ahead,
// otherwise nearest pending floor with ties to the lower floor.
module lift3_dispatch
   import lift3_pkg::*;
#(
   parameter int unsigned N_FLOORS = 3,
   parameter int unsigned FW       = 2
) (
   input  logic [N_FLOORS-1:0] pend,
   input  logic [FW-1:0]       floor,
   input  dir_e                pref,
   output dir_e                go
);
   logic          have_up, have_dn;
   logic [FW-1:0] near_up, near_dn;
   logic [FW-1:0] dist_up, dist_dn;

   always_comb begin
      have_up = 1'b0;
      have_dn = 1'b0;
      near_up = '0;
      near_dn = '0;
      for (int i = N_FLOORS - 1; i >= 0; i--) begin
         if (pend[i] && FW'(i) > floor) begin
            have_up = 1'b1;
            near_up = FW'(i);
         end
      end
      for (int i = 0; i < N_FLOORS; i++) begin
         if (pend[i] && FW'(i) < floor) begin
            have_dn = 1'b1;
            near_dn = FW'(i);
         end
      end
      dist_up = near_up - floor;
      dist_dn = floor - near_dn;

      if (pref == DIR_UP && have_up)       go = DIR_UP;
      else if (pref == DIR_DN && have_dn)  go = DIR_DN;
      else if (have_up && have_dn)         go = (dist_dn <= dist_up) ? DIR_DN : DIR_UP;
      else if (have_up)                    go = DIR_UP;
      else if (have_dn)                    go = DIR_DN;
      else                                 go = DIR_NONE;
   end
endmodule

// File: rtl/lift3_ctrl.sv
module lift3_ctrl
   import lift3_pkg::*;
#(
   parameter int unsigned CLK_HZ       = 50_000_000,
   parameter int unsigned SECS_PER_HOP = 3,
   parameter int unsigned DWELL_CYC    = 2,
   parameter int unsigned N_FLOORS     = 3,
   localparam int unsigned FW          = $clog2(N_FLOORS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_FLOORS-1:0] dest_btn,
   input  logic [N_FLOORS-1:0] call_btn,
   output logic [FW-1:0]       floor_o,
   output logic                door_open_o,
   output logic                moving_up_o,
   output logic                moving_dn_o,
   output logic [N_FLOORS-1:0] dest_lamp_o,
   output logic [N_FLOORS-1:0] call_lamp_o
);
   localparam int unsigned HOP_CYC = SECS_PER_HOP * CLK_HZ;
   localparam logic [N_FLOORS-1:0] ONE_HOT0 = N_FLOORS'(1);

   if (N_FLOORS < 2) begin : g_bad_floors
      $error("lift3_ctrl: N_FLOORS must be at least 2");
   end
   if (DWELL_CYC < 1) begin : g_bad_dwell
      $error("lift3_ctrl: DWELL_CYC must be at least 1");
   end
   if (HOP_CYC < 2) begin : g_bad_hop
      $error("lift3_ctrl: hop period must be at least 2 cycles");
   end

   car_st_e             st_q;
   dir_e                dir_q, go_dir;
   logic [FW-1:0]       floor_q, floor_step, look_floor;
   logic [N_FLOORS-1:0] pend, rest;
   logic                in_move, hop_done, dwell_done;
   logic                arrive, stop_here, enter_open, depart;

   assign pend       = dest_lamp_o | call_lamp_o;
   assign in_move    = (st_q == ST_MOVE);
   assign floor_step = (dir_q == DIR_UP) ? floor_q + 1'b1 : floor_q - 1'b1;
   assign arrive     = in_move && hop_done;
   assign look_floor = arrive ? floor_step : floor_q;
   assign stop_here  = arrive && pend[floor_step];
   assign rest       = pend & ~(ONE_HOT0 << floor_step);
   assign enter_open = arrive && (stop_here || go_dir == DIR_NONE);
   assign depart     = !in_move && dwell_done && (|pend) && (go_dir != DIR_NONE);

   lift3_dispatch #(.N_FLOORS(N_FLOORS), .FW(FW)) u_dispatch (
      .pend  (pend),
      .floor (look_floor),
      .pref  (dir_q),
      .go    (go_dir)
   );

   lift3_tick #(.LIMIT(HOP_CYC), .START_FULL(1'b0)) u_hop_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (depart || arrive),
      .en    (in_move),
      .done  (hop_done)
   );

   lift3_tick #(.LIMIT(DWELL_CYC), .START_FULL(1'b1)) u_dwell_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (enter_open),
      .en    (!in_move),
      .done  (dwell_done)
   );

   lift3_req_latch #(.N_FLOORS(N_FLOORS), .FW(FW)) u_dest_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .btn       (dest_btn),
      .door_open (!in_move),
      .floor     (floor_q),
      .clr_en    (enter_open),
      .clr_floor (floor_step),
      .lamp      (dest_lamp_o)
   );

   lift3_req_latch #(.N_FLOORS(N_FLOORS), .FW(FW)) u_call_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .btn       (call_btn),
      .door_open (!in_move),
      .floor     (floor_q),
      .clr_en    (enter_open),
      .clr_floor (floor_step),
      .lamp      (call_lamp_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_OPEN;
         dir_q   <= DIR_NONE;
         floor_q <= '0;
      end else if (depart) begin
         st_q  <= ST_MOVE;
         dir_q <= go_dir;
      end else if (arrive) begin
         floor_q <= floor_step;
         if (enter_open) begin
            st_q  <= ST_OPEN;
            dir_q <= (|rest) ? dir_q : DIR_NONE;
         end else begin
            dir_q <= go_dir;
         end
      end
   end

   assign floor_o     = floor_q;
   assign door_open_o = !in_move;
   assign moving_up_o = in_move && (dir_q == DIR_UP);
   assign moving_dn_o = in_move && (dir_q == DIR_DN);
endmodule

// File: rtl/lift3_ctrl_chk.sv
module lift3_ctrl_chk #(
   parameter int unsigned N_FLOORS = 3,
   localparam int unsigned FW      = $clog2(N_FLOORS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [FW-1:0]       floor_o,
   input logic                door_open_o,
   input logic                moving_up_o,
   input logic                moving_dn_o,
   input logic [N_FLOORS-1:0] dest_lamp_o,
   input logic [N_FLOORS-1:0] call_lamp_o
);
   logic [FW-1:0] prev_fl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_fl <= '0;
      else        prev_fl <= floor_o;
   end

   AST_FLOOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(floor_o) < N_FLOORS); // R1

   AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(moving_up_o && moving_dn_o)); // R11

   AST_STILL_WHEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      door_open_o |-> (!moving_up_o && !moving_dn_o)); // R11

   AST_FLOOR_ONLY_IN_MOTION: assert property (@(posedge clk) disable iff (!rst_n)
      (floor_o != $past(floor_o)) |-> $past(moving_up_o || moving_dn_o)); // R6

   AST_ARRIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(door_open_o) |-> (!dest_lamp_o[floor_o] && !call_lamp_o[floor_o])); // R5

   AST_OPEN_FLOOR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      door_open_o |=> (!dest_lamp_o[prev_fl] && !call_lamp_o[prev_fl])); // R7
endmodule

bind lift3_ctrl lift3_ctrl_chk #(.N_FLOORS(N_FLOORS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .floor_o     (floor_o),
   .door_open_o (door_open_o),
   .moving_up_o (moving_up_o),
   .moving_dn_o (moving_dn_o),
   .dest_lamp_o (dest_lamp_o),
   .call_lamp_o (call_lamp_o)
);

// File: tb/lift3_ctrl_tb_top.sv
module lift3_ctrl_tb_top;
   localparam int unsigned CLK_HZ = 4;
   localparam int unsigned SECS   = 3;
   localparam int unsigned DWELL  = 3;
   localparam int          HOP    = CLK_HZ * SECS;   // 12 cycles per hop

   typedef struct {
      int         cyc;
      logic [1:0] fl;
      logic       door;
      logic       up;
      logic       dn;
      logic [2:0] dl;
      logic [2:0] cl;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] dest_btn = '0;
   logic [2:0] call_btn = '0;
   logic [1:0] floor_o;
   logic       door_open_o, moving_up_o, moving_dn_o;
   logic [2:0] dest_lamp_o, call_lamp_o;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   int   base = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   lift3_ctrl #(.CLK_HZ(CLK_HZ), .SECS_PER_HOP(SECS), .DWELL_CYC(DWELL), .N_FLOORS(3)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dest_btn    (dest_btn),
      .call_btn    (call_btn),
      .floor_o     (floor_o),
      .door_open_o (door_open_o),
      .moving_up_o (moving_up_o),
      .moving_dn_o (moving_dn_o),
      .dest_lamp_o (dest_lamp_o),
      .call_lamp_o (call_lamp_o)
   );

   // driver side: expected item due at base + d
   task automatic expect_at(input int d, input logic [1:0] fl, input logic door,
                            input logic up, input logic dn, input logic [2:0] dl,
                            input logic [2:0] cl, input string tag);
      exp_t e;
      e.cyc = base + d; e.fl = fl; e.door = door; e.up = up; e.dn = dn;
      e.dl = dl; e.cl = cl; e.tag = tag;
      q.push_back(e);
   endtask

   // called at a negedge: pulse buttons for one cycle
   task automatic press(input logic [2:0] d, input logic [2:0] c);
      dest_btn = d;
      call_btn = c;
      @(negedge clk);
      dest_btn = '0;
      call_btn = '0;
   endtask

   task automatic settle();
      while (q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   // monitor: compare every item due in this cycle
   always @(negedge clk) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].cyc == cyc) begin
            n_chk++;
            if ({floor_o, door_open_o, moving_up_o, moving_dn_o, dest_lamp_o, call_lamp_o} !==
                {q[i].fl, q[i].door, q[i].up, q[i].dn, q[i].dl, q[i].cl}) begin
               n_bad++;
               $display("FAIL %s cyc %0d: actual fl=%0d door=%b up=%b dn=%b dl=%b cl=%b expected fl=%0d door=%b up=%b dn=%b dl=%b cl=%b",
                        q[i].tag, cyc, floor_o, door_open_o, moving_up_o, moving_dn_o,
                        dest_lamp_o, call_lamp_o, q[i].fl, q[i].door, q[i].up, q[i].dn,
                        q[i].dl, q[i].cl);
            end
            q.delete(i);
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: actual cycle %0d expected completion before 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R2: reset state
      @(negedge clk); base = cyc;
      expect_at(1, 0, 1, 0, 0, 3'b000, 3'b000, "R2");
      settle();

      // R7: both buttons for the floor the open car stands at
      @(negedge clk); base = cyc;
      expect_at(1, 0, 1, 0, 0, 3'b000, 3'b000, "R7");
      expect_at(3, 0, 1, 0, 0, 3'b000, 3'b000, "R11");
      press(3'b001, 3'b001);
      settle();

      // R3/R6/R1: ground to second, passing floor 1
      @(negedge clk); base = cyc;
      expect_at(1, 0, 1, 0, 0, 3'b100, 3'b000, "R3");
      expect_at(2, 0, 0, 1, 0, 3'b100, 3'b000, "R3");
      expect_at(1 + HOP, 0, 0, 1, 0, 3'b100, 3'b000, "R6");
      expect_at(2 + HOP, 1, 0, 1, 0, 3'b100, 3'b000, "R1");
      expect_at(1 + 2*HOP, 1, 0, 1, 0, 3'b100, 3'b000, "R6");
      expect_at(2 + 2*HOP, 2, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b100, 3'b000);
      settle();

      // R4: hall call from ground while at second
      @(negedge clk); base = cyc;
      expect_at(1, 2, 1, 0, 0, 3'b000, 3'b001, "R4");
      expect_at(2, 2, 0, 0, 1, 3'b000, 3'b001, "R4");
      expect_at(2 + HOP, 1, 0, 0, 1, 3'b000, 3'b001, "R6");
      expect_at(2 + 2*HOP, 0, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b000, 3'b001);
      settle();

      // R8: call at floor 1 appears mid-hop, car stops there and dwells
      @(negedge clk); base = cyc;
      expect_at(2, 0, 0, 1, 0, 3'b100, 3'b000, "R3");
      expect_at(2 + HOP, 1, 1, 0, 0, 3'b100, 3'b000, "R8");
      expect_at(1 + HOP + DWELL, 1, 1, 0, 0, 3'b100, 3'b000, "R8");
      expect_at(2 + HOP + DWELL, 1, 0, 1, 0, 3'b100, 3'b000, "R8");
      expect_at(2 + 2*HOP + DWELL, 2, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b100, 3'b000);
      repeat (3) @(negedge clk);
      expect_at(5, 0, 0, 1, 0, 3'b100, 3'b010, "R4");
      press(3'b000, 3'b010);
      settle();

      // second to first, arrive idle
      @(negedge clk); base = cyc;
      expect_at(2, 2, 0, 0, 1, 3'b010, 3'b000, "R3");
      expect_at(2 + HOP, 1, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b010, 3'b000);
      settle();

      // R10: idle at floor 1, equal-distance requests both sides -> lower first
      @(negedge clk); base = cyc;
      expect_at(1, 1, 1, 0, 0, 3'b101, 3'b000, "R3");
      expect_at(2, 1, 0, 0, 1, 3'b101, 3'b000, "R10");
      expect_at(2 + HOP, 0, 1, 0, 0, 3'b100, 3'b000, "R5");
      expect_at(2 + HOP + DWELL, 0, 0, 1, 0, 3'b100, 3'b000, "R9");
      expect_at(2 + 2*HOP + DWELL, 1, 0, 1, 0, 3'b100, 3'b000, "R8");
      expect_at(2 + 3*HOP + DWELL, 2, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b101, 3'b000);
      settle();

      // R9: heading down keeps down past work behind, then reverses
      @(negedge clk); base = cyc;
      expect_at(2, 2, 0, 0, 1, 3'b001, 3'b000, "R3");
      expect_at(2 + HOP, 1, 1, 0, 0, 3'b001, 3'b100, "R8");
      expect_at(2 + HOP + DWELL, 1, 0, 0, 1, 3'b001, 3'b100, "R9");
      expect_at(2 + 2*HOP + DWELL, 0, 1, 0, 0, 3'b000, 3'b100, "R5");
      expect_at(2 + 2*HOP + 2*DWELL, 0, 0, 1, 0, 3'b000, 3'b100, "R9");
      expect_at(2 + 3*HOP + 2*DWELL, 1, 0, 1, 0, 3'b000, 3'b100, "R9");
      expect_at(2 + 4*HOP + 2*DWELL, 2, 1, 0, 0, 3'b000, 3'b000, "R5");
      press(3'b001, 3'b000);
      repeat (3) @(negedge clk);
      expect_at(5, 2, 0, 0, 1, 3'b011, 3'b100, "R4");
      press(3'b010, 3'b100);
      settle();

      done = 1'b1;
      foreach (q[i]) begin
         n_bad++;
         $display("FAIL %s: actual never compared expected due at cycle %0d", q[i].tag, q[i].cyc);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule